// File: doc/BRIEF.md
# Triggered Delay-and-Pulse Generator

This block emits a single, precisely placed output pulse in response to an external trigger. Software-facing logic feeds it three timing words through a small serial load port. Software then arms it. Once armed, the block watches an asynchronous trigger line for a rising edge. When it sees one, it runs three phases in turn: a pre-delay counted in system clock cycles, a high pulse of programmed width, and a low hold interval. Only after the hold interval does it report completion with a one-cycle strobe.

All times are whole clock cycles, so resolution equals the clock period. At a few hundred megahertz, pulses of a few tens of nanoseconds are reachable, well under one microsecond. The trigger passes through a synchronizer chain before edge detection. The timing words are copied into shadow registers when the block is armed, so the load port may be reused while a shot is in flight. Each shot needs its own arm.

Top module: `trig_pulse_gen`

## Requirements
- R1: Out of reset, `pulse_out`, `busy` and `done` are low, and the next load word goes to the width slot.
- R2: Successive load words fill three slots in a fixed rotation: the first is the pulse width, the second is the hold count, the third is the pre-delay, and the fourth starts again at the width.
- R3: An `arm` pulse sampled while idle copies the staged words into shadow registers and raises `busy` at that same clock edge.
- R4: While armed, a low-to-high change of `trig_in` is taken through two synchronizer flops. With pre-delay D, `pulse_out` rises at the 3+D-th rising clock edge after the change.
- R5: `pulse_out` stays high for exactly W clock cycles, where W is the width word.
- R6: After the pulse, the output stays low for H cycles, where H is the hold word. `done` is then high for exactly one cycle, starting at edge 3+D+W+H, and `busy` falls at the same edge.
- R7: A width of zero produces no pulse. The hold and completion timing still follow R6 with W=0.
- R8: A pre-delay of zero raises the pulse at the edge right after the one where the synchronized edge is detected, which is edge 3 after the trigger change.
- R9: A trigger edge has no effect unless the block is armed. After completion, further edges are ignored until the next arm.
- R10: A trigger that is already high when the block is armed does not start a shot. A fresh rising edge is required.
- R11: Words loaded during a shot do not change that shot's timing. They take effect at the next arm.
- R12: An `arm` pulse while a shot is running is ignored and leaves the shot's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts its rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Write strobe for the timing-word load port |
| ld_data | input | CNT_W | Timing word written into the current slot |
| arm | input | 1 | Arms the block and latches the staged words (idle only) |
| trig_in | input | 1 | Asynchronous trigger; a rising edge starts an armed shot |
| pulse_out | output | 1 | Active-high timed pulse |
| busy | output | 1 | High from arm until completion |
| done | output | 1 | One-cycle completion strobe |

## Verification
Every result is due a fixed number of edges after the trigger changes. The pulse rises at edge 3+D, falls at edge 3+D+W, and `done` pulses while `busy` falls at edge 3+D+W+H; `busy` itself rises at the arm edge. The bench drives the trigger on a falling edge and counts rising edges from that point. After each rising edge it samples on the next falling edge, comparing all three outputs against these formulas on every cycle of the shot and a few cycles beyond. The ignore cases (no arm, a level already high, a second edge after completion) are judged by holding every output at its expected idle or armed value across a window longer than any start latency.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ARMED = 3'd1,
        PH_DELAY = 3'd2,
        PH_PULSE = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    // Load-port slot rotation: width, then hold, then pre-delay
    typedef enum logic [1:0] {
        SLOT_WIDTH = 2'd0,
        SLOT_HOLD  = 2'd1,
        SLOT_DELAY = 2'd2
    } slot_e;

    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/tpg_trig_sync.sv
`timescale 1ns/1ps
module tpg_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = trig_async;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.prev = sync_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign trig_rise = sync_q.chain[LAST] & ~sync_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise); // R4

endmodule

// File: rtl/tpg_param_load.sv
`timescale 1ns/1ps
module tpg_param_load
    import tpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] stg_width,
    output logic [CNT_W-1:0] stg_hold,
    output logic [CNT_W-1:0] stg_delay
);
    typedef struct packed {
        slot_e            slot;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] delay;
    } load_t;

    load_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (ld_valid) begin
            unique case (ld_q.slot)
                SLOT_WIDTH: begin
                    ld_d.width = ld_data;
                    ld_d.slot  = SLOT_HOLD;
                end
                SLOT_HOLD: begin
                    ld_d.hold = ld_data;
                    ld_d.slot = SLOT_DELAY;
                end
                SLOT_DELAY: begin
                    ld_d.delay = ld_data;
                    ld_d.slot  = SLOT_WIDTH;
                end
                default: ld_d.slot = SLOT_WIDTH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q       <= '0;
            ld_q.slot  <= SLOT_WIDTH;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign stg_width = ld_q.width;
    assign stg_hold  = ld_q.hold;
    assign stg_delay = ld_q.delay;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ld_q.slot) < NUM_SLOTS); // R2

    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> $stable(ld_q.slot)); // R2

endmodule

// File: rtl/tpg_seq.sv
`timescale 1ns/1ps
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig_rise,
    input  logic [CNT_W-1:0] stg_width,
    input  logic [CNT_W-1:0] stg_hold,
    input  logic [CNT_W-1:0] stg_delay,
    output logic             pulse_out,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sh_width;
        logic [CNT_W-1:0] sh_hold;
        logic [CNT_W-1:0] sh_delay;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic after_delay;
    logic after_pulse;
    logic finish;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        after_delay = 1'b0;
        after_pulse = 1'b0;
        finish      = 1'b0;

        unique case (seq_q.phase)
            PH_IDLE: begin
                if (arm) begin
                    seq_d.sh_width = stg_width;
                    seq_d.sh_hold  = stg_hold;
                    seq_d.sh_delay = stg_delay;
                    seq_d.phase    = PH_ARMED;
                end
            end
            PH_ARMED: begin
                if (trig_rise) begin
                    if (seq_q.sh_delay != '0) begin
                        seq_d.phase = PH_DELAY;
                        seq_d.cnt   = seq_q.sh_delay;
                    end else begin
                        after_delay = 1'b1;
                    end
                end
            end
            PH_DELAY: begin
                if (seq_q.cnt == ONE) after_delay = 1'b1;
                else                  seq_d.cnt   = seq_q.cnt - ONE;
            end
            PH_PULSE: begin
                if (seq_q.cnt == ONE) after_pulse = 1'b1;
                else                  seq_d.cnt   = seq_q.cnt - ONE;
            end
            PH_HOLD: begin
                if (seq_q.cnt == ONE) finish    = 1'b1;
                else                  seq_d.cnt = seq_q.cnt - ONE;
            end
            default: seq_d.phase = PH_IDLE;
        endcase

        // Phase routing: a zero count skips its phase entirely
        if (after_delay) begin
            if (seq_q.sh_width != '0) begin
                seq_d.phase = PH_PULSE;
                seq_d.cnt   = seq_q.sh_width;
            end else begin
                after_pulse = 1'b1;
            end
        end
        if (after_pulse) begin
            if (seq_q.sh_hold != '0) begin
                seq_d.phase = PH_HOLD;
                seq_d.cnt   = seq_q.sh_hold;
            end else begin
                finish = 1'b1;
            end
        end
        if (finish) begin
            seq_d.phase = PH_IDLE;
            seq_d.cnt   = '0;
            seq_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pulse_out = (seq_q.phase == PH_PULSE);
    assign busy      = (seq_q.phase != PH_IDLE);
    assign done      = seq_q.done;

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.phase) == PH_ARMED && seq_q.phase != PH_ARMED)
            |-> $past(trig_rise)); // R4

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase inside {PH_DELAY, PH_PULSE, PH_HOLD})
            |-> (seq_q.cnt != '0)); // R5

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.phase) != PH_IDLE)
            |-> ($stable(seq_q.sh_width) && $stable(seq_q.sh_hold)
                 && $stable(seq_q.sh_delay))); // R11

    AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.phase) == PH_IDLE && seq_q.phase != PH_IDLE)
            |-> $past(arm)); // R9

endmodule

// File: rtl/trig_pulse_gen.sv
`timescale 1ns/1ps
module trig_pulse_gen #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             arm,
    input  logic             trig_in,
    output logic             pulse_out,
    output logic             busy,
    output logic             done
);
    logic             trig_rise;
    logic [CNT_W-1:0] stg_width;
    logic [CNT_W-1:0] stg_hold;
    logic [CNT_W-1:0] stg_delay;

    tpg_trig_sync #(
        .STAGES     (SYNC_STAGES)
    ) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_rise  (trig_rise)
    );

    tpg_param_load #(
        .CNT_W      (CNT_W)
    ) load_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_data    (ld_data),
        .stg_width  (stg_width),
        .stg_hold   (stg_hold),
        .stg_delay  (stg_delay)
    );

    tpg_seq #(
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .trig_rise  (trig_rise),
        .stg_width  (stg_width),
        .stg_hold   (stg_hold),
        .stg_delay  (stg_delay),
        .pulse_out  (pulse_out),
        .busy       (busy),
        .done       (done)
    );

    AST_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> busy); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6

endmodule

// File: tb/trig_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module trig_pulse_gen_tb_top;

    localparam int CNT_W = 16;
    localparam int NVEC  = 8;

    typedef struct packed {
        int d;
        int w;
        int h;
        int done_t;
    } vec_t;

    // Stimulus {pre-delay, width, hold} and expected done edge (3+D+W+H)
    localparam vec_t VEC [NVEC] = '{
        '{2, 3, 1,  9},
        '{5, 1, 4, 13},
        '{0, 4, 2,  9},
        '{3, 0, 2,  8},
        '{0, 0, 0,  3},
        '{1, 1, 0,  5},
        '{7, 5, 3, 18},
        '{0, 1, 1,  5}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_valid = 1'b0;
    logic [CNT_W-1:0] ld_data = '0;
    logic             arm = 1'b0;
    logic             trig_in = 1'b0;
    logic             pulse_out;
    logic             busy;
    logic             done;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trig_pulse_gen #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .arm       (arm),
        .trig_in   (trig_in),
        .pulse_out (pulse_out),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Three words in rotation: width, hold, pre-delay
    task automatic load3(input int w, input int h, input int d);
        ld_valid = 1'b1;
        ld_data  = CNT_W'(w); cyc(1);
        ld_data  = CNT_W'(h); cyc(1);
        ld_data  = CNT_W'(d); cyc(1);
        ld_valid = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        cyc(1);
        arm = 1'b0;
    endtask

    // Caller stands at a falling edge with the block armed and trig low.
    task automatic run_shot(input int d, input int w, input int h, input string tag);
        int last;
        last = 3 + d + w + h;
        trig_in = 1'b1;
        for (int t = 1; t <= last + 3; t++) begin
            cyc(1);
            chk($sformatf("%s pulse edge=%0d", (t == 3 + d) ? "R4" : tag, t),
                int'(pulse_out), int'(t >= 3 + d && t < 3 + d + w));
            chk($sformatf("R6 done edge=%0d", t), int'(done), int'(t == last));
            chk($sformatf("R6 busy edge=%0d", t), int'(busy), int'(t < last));
        end
        trig_in = 1'b0;
        cyc(3);
    endtask

    task automatic quiet(input int n, input int exp_busy, input string tag);
        for (int t = 0; t < n; t++) begin
            cyc(1);
            chk($sformatf("%s pulse idle", tag), int'(pulse_out), 0);
            chk($sformatf("%s done idle", tag), int'(done), 0);
            chk($sformatf("%s busy level", tag), int'(busy), exp_busy);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 pulse reset", int'(pulse_out), 0);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk; R2 slot rotation is exercised by each load3
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = (VEC[v].w == 0) ? "R7" : (VEC[v].d == 0) ? "R8" : "R5";
            load3(VEC[v].w, VEC[v].h, VEC[v].d);
            do_arm();
            chk("R3 busy after arm", int'(busy), 1);
            run_shot(VEC[v].d, VEC[v].w, VEC[v].h, tag);
            chk("R6 table done edge", 3 + VEC[v].d + VEC[v].w + VEC[v].h, VEC[v].done_t);
        end

        // R9: trigger edge without arm
        trig_in = 1'b1;
        quiet(8, 0, "R9");
        trig_in = 1'b0;
        cyc(3);

        // R9: after a completed shot, new edge is ignored without re-arm
        load3(2, 1, 1);
        do_arm();
        run_shot(1, 2, 1, "R5");
        trig_in = 1'b1;
        quiet(8, 0, "R9");
        trig_in = 1'b0;
        cyc(3);

        // R10: trigger already high at arm time does not start
        trig_in = 1'b1;
        cyc(4);
        do_arm();
        quiet(8, 1, "R10");
        trig_in = 1'b0;
        cyc(4);
        run_shot(1, 2, 1, "R10");

        // R11: loads during a shot do not disturb it; used at next arm
        load3(3, 2, 4);
        do_arm();
        fork
            run_shot(4, 3, 2, "R11");
            begin
                cyc(2);
                load3(1, 1, 1);
            end
        join
        do_arm();
        run_shot(1, 1, 1, "R11");

        // R12: arm during a running shot is ignored
        load3(2, 2, 3);
        do_arm();
        fork
            run_shot(3, 2, 2, "R12");
            begin
                cyc(4);
                do_arm();
            end
        join
        chk("R12 idle after shot", int'(busy), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule